// File: doc/BRIEF.md
# Dual-Clock Mailbox Register

This block carries a single data word from a writer running on clock B to a reader running on clock A. It sits beside a bidirectional FIFO and bypasses it. Urgent control words reach the other side without queuing behind FIFO traffic. The writer loads the word by selecting a write with its mailbox select high. From that edge on, a flag blocks further loads until the reader has taken the word.

Each side sees its own copy of the flag. The writer's copy is low while a word is outstanding. The reader's copy is low while a word is waiting for it. The set event is a toggle in the writer domain. The clear event is a toggle in the reader domain. Each toggle reaches the other domain through a two-flop synchronizer, so neither flag depends on a combinational path across the clock boundary.

The reader sees the stored word on its data bus whenever it selects a mailbox read. A read made while its flag is high returns the last word again and has no other effect.

Top module: `mbx_xfer`

## Requirements
- R1: After reset both flags, `a_mb_flag_n` and `b_mb_flag_n`, are HIGH (1 = empty and writable), and the stored word is all zeros.
- R2: On a rising `clk_b` edge with `b_dir_wr`=1, `b_mb_sel`=1 and `b_mb_flag_n`=1, the word on `b_wr_data` is stored, and `b_mb_flag_n` is LOW right after that edge.
- R3: While `b_mb_flag_n` is LOW, mailbox writes from port B are ignored and the stored word is unchanged.
- R4: A port B edge with `b_mb_sel`=0, or with `b_dir_wr`=0, stores nothing and leaves `b_mb_flag_n` HIGH.
- R5: After the `clk_b` edge that stores a word, `a_mb_flag_n` goes LOW within 1 to 3 rising `clk_a` edges.
- R6: On a rising `clk_a` edge with `a_dir_wr`=0, `a_mb_sel`=1 and `a_mb_flag_n`=0, `a_mb_flag_n` is HIGH right after the edge. `b_mb_flag_n` returns HIGH within 1 to 3 rising `clk_b` edges.
- R7: While `a_dir_wr`=0 and `a_mb_sel`=1, `a_rd_data` equals the stored word. Otherwise `a_rd_data` is zero.
- R8: A port A mailbox read while `a_mb_flag_n` is HIGH changes neither flag, and the stale word is returned.
- R9: A port A edge with `a_dir_wr`=1 does not clear the flag, even when `a_mb_sel`=1.
- R10: For any ratio of the two clocks, every word stored is delivered to port A exactly once and in order, and none is overwritten before it is read. Whenever `a_mb_flag_n` is LOW, `b_mb_flag_n` is also LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_a | input | 1 | Reader clock |
| a_dir_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mb_sel | input | 1 | Port A mailbox select |
| a_rd_data | output | WIDTH | Stored word while a mailbox read is selected, else zero |
| a_mb_flag_n | output | 1 | Reader flag, LOW while a word is waiting |
| clk_b | input | 1 | Writer clock |
| b_dir_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_mb_sel | input | 1 | Port B mailbox select |
| b_wr_data | input | WIDTH | Word to store |
| b_mb_flag_n | output | 1 | Writer flag, LOW while a word is outstanding |

## Verification
The hardest case to reach is a write attempt that lands in the window after the reader has cleared its flag but before the clear toggle has come through to the writer. A wrong design would accept an overwrite or lose an acknowledge in that window. The bench runs a free-flowing writer and reader that retry as soon as each sees its own flag permit it. It repeats this under several unrelated clock-B periods, some faster and some slower than clock A, so the retry edges sweep across the synchronizer latency. Every word is compared against an arithmetic sequence.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // A side has work pending when its own toggle differs from the far one.
  function automatic logic tog_pending(input logic mine, input logic theirs);
    return mine ^ theirs;
  endfunction

  function automatic logic is_mb_write(input logic dir_wr, input logic sel);
    return dir_wr & sel;
  endfunction

  function automatic logic is_mb_read(input logic dir_wr, input logic sel);
    return ~dir_wr & sel;
  endfunction

endpackage

// File: rtl/mbx_tog_sync.sv
module mbx_tog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/mbx_wr_side.sv
module mbx_wr_side
  import mbx_pkg::*;
#(
  parameter int WIDTH = 36
) (
  input  logic             clk_b,
  input  logic             rst_n,
  input  logic             dir_wr,
  input  logic             sel,
  input  logic [WIDTH-1:0] din,
  input  logic             ack_sync,
  output logic             wr_tog,
  output logic [WIDTH-1:0] word,
  output logic             flag_n,
  output logic             accept
);
  logic busy;

  assign busy   = tog_pending(wr_tog, ack_sync);
  assign flag_n = ~busy;
  assign accept = is_mb_write(dir_wr, sel) & ~busy;

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      wr_tog <= 1'b0;
      word   <= '0;
    end else if (accept) begin
      wr_tog <= ~wr_tog;
      word   <= din;
    end
  end
endmodule

// File: rtl/mbx_rd_side.sv
module mbx_rd_side
  import mbx_pkg::*;
#(
  parameter int WIDTH = 36
) (
  input  logic             clk_a,
  input  logic             rst_n,
  input  logic             dir_wr,
  input  logic             sel,
  input  logic             req_sync,
  input  logic [WIDTH-1:0] word_in,
  output logic             rd_tog,
  output logic             flag_n,
  output logic             clear,
  output logic [WIDTH-1:0] rd_data
);
  logic avail;
  logic rd_sel;

  assign avail   = tog_pending(req_sync, rd_tog);
  assign flag_n  = ~avail;
  assign rd_sel  = is_mb_read(dir_wr, sel);
  assign clear   = rd_sel & avail;
  assign rd_data = rd_sel ? word_in : '0;

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n)     rd_tog <= 1'b0;
    else if (clear) rd_tog <= ~rd_tog;
  end
endmodule

// File: rtl/mbx_xfer.sv
module mbx_xfer #(
  parameter int WIDTH       = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rst_n,
  input  logic             clk_a,
  input  logic             a_dir_wr,
  input  logic             a_mb_sel,
  output logic [WIDTH-1:0] a_rd_data,
  output logic             a_mb_flag_n,
  input  logic             clk_b,
  input  logic             b_dir_wr,
  input  logic             b_mb_sel,
  input  logic [WIDTH-1:0] b_wr_data,
  output logic             b_mb_flag_n
);
  logic             wr_tog;
  logic             rd_tog;
  logic             wr_tog_a;
  logic             rd_tog_b;
  logic [WIDTH-1:0] word;
  logic             wr_accept;
  logic             rd_clear;

  mbx_wr_side #(.WIDTH(WIDTH)) u_wr (
    .clk_b(clk_b), .rst_n(rst_n), .dir_wr(b_dir_wr), .sel(b_mb_sel),
    .din(b_wr_data), .ack_sync(rd_tog_b), .wr_tog(wr_tog), .word(word),
    .flag_n(b_mb_flag_n), .accept(wr_accept)
  );

  mbx_tog_sync #(.STAGES(SYNC_STAGES)) u_sync_to_a (
    .clk(clk_a), .rst_n(rst_n), .d(wr_tog), .q(wr_tog_a)
  );

  mbx_tog_sync #(.STAGES(SYNC_STAGES)) u_sync_to_b (
    .clk(clk_b), .rst_n(rst_n), .d(rd_tog), .q(rd_tog_b)
  );

  mbx_rd_side #(.WIDTH(WIDTH)) u_rd (
    .clk_a(clk_a), .rst_n(rst_n), .dir_wr(a_dir_wr), .sel(a_mb_sel),
    .req_sync(wr_tog_a), .word_in(word), .rd_tog(rd_tog),
    .flag_n(a_mb_flag_n), .clear(rd_clear), .rd_data(a_rd_data)
  );
endmodule

// File: rtl/mbx_xfer_chk.sv
module mbx_xfer_chk #(
  parameter int WIDTH = 36
) (
  input logic             rst_n,
  input logic             clk_a,
  input logic             clk_b,
  input logic             a_dir_wr,
  input logic             a_mb_sel,
  input logic             a_mb_flag_n,
  input logic             b_dir_wr,
  input logic             b_mb_sel,
  input logic             b_mb_flag_n,
  input logic [WIDTH-1:0] word,
  input logic             rd_clear
);
  p_flag_low_after_write_r2: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_dir_wr && b_mb_sel && b_mb_flag_n) |=> !b_mb_flag_n);

  p_no_overwrite_r3: assert property (@(posedge clk_b) disable iff (!rst_n)
    !b_mb_flag_n |=> $stable(word));

  p_read_clears_r6: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!a_dir_wr && a_mb_sel && !a_mb_flag_n) |=> a_mb_flag_n);

  p_stale_read_quiet_r8: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_mb_flag_n && a_mb_sel && !a_dir_wr) |-> !rd_clear);

  p_write_sel_keeps_r9: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_dir_wr && !a_mb_flag_n) |=> !a_mb_flag_n);

  p_flag_order_r10: assert property (@(posedge clk_a) disable iff (!rst_n)
    !a_mb_flag_n |-> !b_mb_flag_n);
endmodule

bind mbx_xfer mbx_xfer_chk #(.WIDTH(WIDTH)) u_chk (
  .rst_n(rst_n), .clk_a(clk_a), .clk_b(clk_b),
  .a_dir_wr(a_dir_wr), .a_mb_sel(a_mb_sel), .a_mb_flag_n(a_mb_flag_n),
  .b_dir_wr(b_dir_wr), .b_mb_sel(b_mb_sel), .b_mb_flag_n(b_mb_flag_n),
  .word(word), .rd_clear(rd_clear)
);

// File: tb/sim_mbx_xfer.sv
`timescale 1ns/1ps
module sim_mbx_xfer;
  localparam int W = 36;

  logic         rst_n = 1'b0;
  logic         clk_a = 1'b0;
  logic         clk_b = 1'b0;
  logic         a_dir_wr = 1'b1, a_mb_sel = 1'b0;
  logic         b_dir_wr = 1'b0, b_mb_sel = 1'b0;
  logic [W-1:0] b_wr_data = '0;
  logic [W-1:0] a_rd_data;
  logic         a_mb_flag_n, b_mb_flag_n;

  int  checks = 0, failures = 0;
  bit  done = 0;
  real b_half = 3.7;

  always #2.5 clk_a = ~clk_a;
  always #(b_half) clk_b = ~clk_b;

  mbx_xfer #(.WIDTH(W), .SYNC_STAGES(2)) u0 (
    .rst_n(rst_n), .clk_a(clk_a), .a_dir_wr(a_dir_wr), .a_mb_sel(a_mb_sel),
    .a_rd_data(a_rd_data), .a_mb_flag_n(a_mb_flag_n), .clk_b(clk_b),
    .b_dir_wr(b_dir_wr), .b_mb_sel(b_mb_sel), .b_wr_data(b_wr_data),
    .b_mb_flag_n(b_mb_flag_n)
  );

  task automatic chk(input string req, input bit ok, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pattern(input int run, input int idx);
    logic [31:0] mix;
    mix = (32'(idx) + 32'd1) * 32'h9E37_79B9;
    return {4'(run), mix};
  endfunction

  // Mailbox write on port B; returns once the edge has been taken.
  task automatic b_write(input logic [W-1:0] d, input bit use_sel, input bit dir);
    @(negedge clk_b);
    b_dir_wr = dir; b_mb_sel = use_sel; b_wr_data = d;
    @(posedge clk_b);
    @(negedge clk_b);
    b_dir_wr = 1'b0; b_mb_sel = 1'b0;
  endtask

  // Read on port A; returns the data seen before the edge.
  task automatic a_read(output logic [W-1:0] d);
    @(negedge clk_a);
    a_dir_wr = 1'b0; a_mb_sel = 1'b1;
    #0.2 d = a_rd_data;
    @(posedge clk_a);
    @(negedge clk_a);
    a_dir_wr = 1'b1; a_mb_sel = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk_a);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] got;
    int n;
    repeat (4) @(posedge clk_a);
    #1 rst_n = 1'b1;
    @(negedge clk_a);
    // R1 reset state
    chk("R1 a flag", a_mb_flag_n == 1'b1, W'(a_mb_flag_n), W'(1));
    chk("R1 b flag", b_mb_flag_n == 1'b1, W'(b_mb_flag_n), W'(1));
    chk("R7 idle data zero", a_rd_data == '0, a_rd_data, '0);
    a_read(got);
    chk("R1 word zero", got == '0, got, '0);

    // R4 non-mailbox or read-direction edges store nothing
    b_write(36'hA_AAAA_AAAA, 1'b0, 1'b1);
    chk("R4 no sel flag", b_mb_flag_n == 1'b1, W'(b_mb_flag_n), W'(1));
    b_write(36'hB_BBBB_BBBB, 1'b1, 1'b0);
    chk("R4 read dir flag", b_mb_flag_n == 1'b1, W'(b_mb_flag_n), W'(1));
    a_read(got);
    chk("R4 word kept", got == '0, got, '0);

    // R2 and R5: store a word, measure the reader latency
    @(negedge clk_b);
    b_dir_wr = 1'b1; b_mb_sel = 1'b1; b_wr_data = 36'h1_2345_6789;
    @(posedge clk_b);
    n = 0;
    do begin @(posedge clk_a); #0.1 n++; end while (a_mb_flag_n && n < 6);
    chk("R5 latency", n >= 1 && n <= 3, W'(n), W'(3));
    @(negedge clk_b);
    b_dir_wr = 1'b0; b_mb_sel = 1'b0;
    chk("R2 b flag low", b_mb_flag_n == 1'b0, W'(b_mb_flag_n), W'(0));

    // R3 write while outstanding is dropped
    b_write(36'hF_0F0F_0F0F, 1'b1, 1'b1);
    chk("R3 b flag still low", b_mb_flag_n == 1'b0, W'(b_mb_flag_n), W'(0));

    // R9 port A write select does not clear
    @(negedge clk_a); a_dir_wr = 1'b1; a_mb_sel = 1'b1;
    repeat (2) @(negedge clk_a);
    a_mb_sel = 1'b0;
    chk("R9 a flag low", a_mb_flag_n == 1'b0, W'(a_mb_flag_n), W'(0));
    chk("R9 b flag low", b_mb_flag_n == 1'b0, W'(b_mb_flag_n), W'(0));
    chk("R7 unselected zero", a_rd_data == '0, a_rd_data, '0);

    // R6: read clears; R7 data; R3 first word kept
    @(negedge clk_a);
    a_dir_wr = 1'b0; a_mb_sel = 1'b1;
    #0.2 got = a_rd_data;
    chk("R3 R7 word", got == 36'h1_2345_6789, got, 36'h1_2345_6789);
    @(posedge clk_a);
    n = 0;
    do begin @(posedge clk_b); #0.1 n++; end while (!b_mb_flag_n && n < 6);
    chk("R6 b latency", n >= 1 && n <= 3, W'(n), W'(3));
    @(negedge clk_a);
    chk("R6 a flag high", a_mb_flag_n == 1'b1, W'(a_mb_flag_n), W'(1));
    a_dir_wr = 1'b1; a_mb_sel = 1'b0;

    // R8 stale read: returns same word, no flag change
    a_read(got);
    chk("R8 stale word", got == 36'h1_2345_6789, got, 36'h1_2345_6789);
    repeat (4) @(negedge clk_b);
    chk("R8 b flag high", b_mb_flag_n == 1'b1, W'(b_mb_flag_n), W'(1));
    chk("R8 a flag high", a_mb_flag_n == 1'b1, W'(a_mb_flag_n), W'(1));

    // R10 streaming sweep over unrelated clock-B periods
    for (int run = 0; run < 5; run++) begin
      case (run)
        0: b_half = 1.3;
        1: b_half = 2.45;
        2: b_half = 3.7;
        3: b_half = 7.9;
        default: b_half = 13.1;
      endcase
      fork
        begin
          for (int i = 0; i < 40; i++) begin
            @(negedge clk_b);
            while (!b_mb_flag_n) @(negedge clk_b);
            b_dir_wr = 1'b1; b_mb_sel = 1'b1; b_wr_data = pattern(run, i);
            @(posedge clk_b);
            @(negedge clk_b);
            b_dir_wr = 1'b0; b_mb_sel = 1'b0;
          end
        end
        begin
          for (int i = 0; i < 40; i++) begin
            logic [W-1:0] r;
            @(negedge clk_a);
            while (a_mb_flag_n) @(negedge clk_a);
            a_read(r);
            chk($sformatf("R10 run%0d word%0d", run, i), r == pattern(run, i),
                r, pattern(run, i));
          end
        end
      join
      repeat (8) @(negedge clk_b);
      chk("R10 drained b", b_mb_flag_n == 1'b1, W'(b_mb_flag_n), W'(1));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule